// File: doc/BRIEF.md
# Configurable Pseudo Dual-Port SRAM

This block is a 16,384-bit on-chip memory with one write port and one read port that share the same storage. The data width is set at elaboration time to 1, 2, 4, 8, 16 or 32 bits. The depth is the capacity divided by that width, and the address width follows from the depth. Each port has its own clock and its own clock enable, so a producer and a consumer in different clock domains can exchange data through the array.

The write side always registers its inputs. Address, data, write enable and the two-bit chip select are sampled on an enabled write-clock edge. The array is updated from those registers on the next write-clock edge. On the read side, the address register and the output data register can each be kept or removed by a parameter. With both kept, read data arrives two read-clock edges after the address. Each register that is removed takes one edge off that latency.

The reset is asynchronous and shared by both ports. It is the OR of a global reset and a local reset. The local reset, both clocks and both clock enables each have a polarity parameter, so the block can sit on active-low or inverted control nets without extra glue logic.

Top module: `pdpram_top`

## Requirements
- R1: The depth is 16384/DATA_W words, addressed by log2(depth) bits. DATA_W is one of 1, 2, 4, 8, 16, 32. The lowest and highest addresses hold independent words.
- R2: A write is accepted only when, on a write-clock edge, the effective write clock enable is active, the write enable is high and the two chip-select bits equal CS_MATCH (default 2'b11). In any other case the memory contents are unchanged.
- R3: Write inputs are sampled on an enabled write-clock edge. The word lands in the array on the following write-clock edge.
- R4: With both read registers present, a new read address shows on the data output after two enabled read-clock edges. With only the data register present, it shows after one edge. With neither present, the output follows the address combinationally.
- R5: While the effective read clock enable is inactive, the read address and read data registers hold their values, and the output does not change.
- R6: When both ports run on one common clock and both read registers are present, a read of the address being written returns the old word on the edge where the write lands. The new word appears one edge later.
- R7: The reset is asynchronous and is the OR of the global and local reset inputs. It clears the read data register and the write registers, which cancels a write that was sampled but not yet committed. It leaves the array contents intact.
- R8: The parameters LRST_INV, WCE_INV, RCE_INV, WCLK_INV and RCLK_INV invert the local reset, the enables and the clocks. When set, the corresponding input is active low, or triggers on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_glb_i | input | 1 | Global asynchronous reset, active high |
| rst_loc_i | input | 1 | Local asynchronous reset, polarity set by LRST_INV |
| wr_clk_i | input | 1 | Write clock, edge set by WCLK_INV |
| wr_ce_i | input | 1 | Write clock enable, polarity set by WCE_INV |
| wr_en_i | input | 1 | Write enable, active high |
| wr_sel_i | input | 2 | Chip select, compared with CS_MATCH |
| wr_addr_i | input | log2(16384/DATA_W) | Write word address |
| wr_data_i | input | DATA_W | Write data |
| rd_clk_i | input | 1 | Read clock, edge set by RCLK_INV |
| rd_ce_i | input | 1 | Read clock enable, polarity set by RCE_INV |
| rd_addr_i | input | log2(16384/DATA_W) | Read word address |
| rd_data_o | output | DATA_W | Read data |

## Verification
The assertions check the per-edge register behaviour on every cycle:
- the chip-select and enable gating of the write commit flag;
- the capture and hold of the write registers;
- the one-edge transfer of the read address register;
- the hold of the read data register while its enable is off;
- a zeroed data register during reset.

Only the bench scenarios can show the properties that involve the array. These are that stored words survive reset and gated writes, that the lowest and highest addresses do not alias, the exact read latency for each register arrangement, and the old-data result of a same-address collision on a common clock.

// File: rtl/pdpram_pkg.sv
package pdpram_pkg;

   localparam int unsigned PDP_TOTAL_BITS = 16384;

   // legal word widths for the array
   function automatic bit pdp_width_ok(input int unsigned w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16) || (w == 32);
   endfunction

   function automatic int unsigned pdp_depth(input int unsigned w);
      return PDP_TOTAL_BITS / w;
   endfunction

endpackage

// File: rtl/pdpram_pol.sv
// Optional inverter on a single control net, chosen at elaboration.
module pdpram_pol #(
   parameter bit INV = 1'b0
) (
   input  logic sig_i,
   output logic sig_o
);
   generate
      if (INV) begin : g_inv
         assign sig_o = ~sig_i;
      end else begin : g_pass
         assign sig_o = sig_i;
      end
   endgenerate
endmodule

// File: rtl/pdpram_wr_stage.sv
// Input registers of the write port; the commit flag folds in the select match.
module pdpram_wr_stage #(
   parameter int unsigned   DATA_W   = 8,
   parameter int unsigned   AW       = 11,
   parameter logic [1:0]    CS_MATCH = 2'b11
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ce_i,
   input  logic              en_i,
   input  logic [1:0]        sel_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              go_o,
   output logic [AW-1:0]     addr_o,
   output logic [DATA_W-1:0] data_o
);
   logic              go_q;
   logic [AW-1:0]     addr_q;
   logic [DATA_W-1:0] data_q;
   logic              sel_hit;

   assign sel_hit = (sel_i == CS_MATCH);

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         go_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (ce_i) begin
         go_q   <= en_i & sel_hit;
         addr_q <= addr_i;
         data_q <= data_i;
      end
   end

   assign go_o   = go_q;
   assign addr_o = addr_q;
   assign data_o = data_q;
endmodule

// File: rtl/pdpram_store.sv
// Storage array: synchronous commit, asynchronous read. Not reset.
module pdpram_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 2048,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              clk_i,
   input  logic              wr_go_i,
   input  logic [AW-1:0]     wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk_i) begin
      if (wr_go_i) begin
         cells[wr_addr_i] <= wr_data_i;
      end
   end

   assign rd_data_o = cells[rd_addr_i];
endmodule

// File: rtl/pdpram_rd_path.sv
// Read path: address register and data register each present or bypassed.
module pdpram_rd_path #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned AW       = 11,
   parameter bit          ADDR_REG = 1'b1,
   parameter bit          DATA_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              ce_i,
   input  logic [AW-1:0]     addr_i,
   output logic [AW-1:0]     mem_addr_o,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [DATA_W-1:0] data_o
);
   generate
      if (ADDR_REG) begin : g_areg
         logic [AW-1:0] addr_q;
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) begin
               addr_q <= '0;
            end else if (ce_i) begin
               addr_q <= addr_i;
            end
         end
         assign mem_addr_o = addr_q;
      end else begin : g_acomb
         assign mem_addr_o = addr_i;
      end

      if (DATA_REG) begin : g_dreg
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) begin
               data_q <= '0;
            end else if (ce_i) begin
               data_q <= mem_data_i;
            end
         end
         assign data_o = data_q;
      end else begin : g_dcomb
         assign data_o = mem_data_i;
      end
   endgenerate
endmodule

// File: rtl/pdpram_top.sv
module pdpram_top
   import pdpram_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter bit          RD_ADDR_REG = 1'b1,
   parameter bit          RD_DATA_REG = 1'b1,
   parameter logic [1:0]  CS_MATCH    = 2'b11,
   parameter bit          WCLK_INV    = 1'b0,
   parameter bit          RCLK_INV    = 1'b0,
   parameter bit          WCE_INV     = 1'b0,
   parameter bit          RCE_INV     = 1'b0,
   parameter bit          LRST_INV    = 1'b0,
   localparam int unsigned DEPTH      = pdp_depth(DATA_W),
   localparam int unsigned AW         = $clog2(DEPTH)
) (
   input  logic              rst_glb_i,
   input  logic              rst_loc_i,
   input  logic              wr_clk_i,
   input  logic              wr_ce_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [AW-1:0]     wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_clk_i,
   input  logic              rd_ce_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);
   // elaboration checks
   if (!pdp_width_ok(DATA_W)) begin : g_bad_width
      $error("pdpram_top: DATA_W must be 1, 2, 4, 8, 16 or 32");
   end
   if (DEPTH * DATA_W != PDP_TOTAL_BITS) begin : g_bad_size
      $error("pdpram_top: depth times width must equal the array capacity");
   end

   logic wclk_e, rclk_e, wce_e, rce_e, rst_loc_e, rst_e;
   logic              wr_go_q;
   logic [AW-1:0]     wr_addr_q;
   logic [DATA_W-1:0] wr_data_q;
   logic [AW-1:0]     rd_mem_addr;
   logic [DATA_W-1:0] rd_mem_data;

   pdpram_pol #(.INV(WCLK_INV)) u_pol_wclk (.sig_i(wr_clk_i),  .sig_o(wclk_e));
   pdpram_pol #(.INV(RCLK_INV)) u_pol_rclk (.sig_i(rd_clk_i),  .sig_o(rclk_e));
   pdpram_pol #(.INV(WCE_INV))  u_pol_wce  (.sig_i(wr_ce_i),   .sig_o(wce_e));
   pdpram_pol #(.INV(RCE_INV))  u_pol_rce  (.sig_i(rd_ce_i),   .sig_o(rce_e));
   pdpram_pol #(.INV(LRST_INV)) u_pol_rst  (.sig_i(rst_loc_i), .sig_o(rst_loc_e));

   assign rst_e = rst_glb_i | rst_loc_e;

   pdpram_wr_stage #(
      .DATA_W   (DATA_W),
      .AW       (AW),
      .CS_MATCH (CS_MATCH)
   ) u_wr (
      .clk_i  (wclk_e),
      .rst_i  (rst_e),
      .ce_i   (wce_e),
      .en_i   (wr_en_i),
      .sel_i  (wr_sel_i),
      .addr_i (wr_addr_i),
      .data_i (wr_data_i),
      .go_o   (wr_go_q),
      .addr_o (wr_addr_q),
      .data_o (wr_data_q)
   );

   pdpram_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk_i     (wclk_e),
      .wr_go_i   (wr_go_q),
      .wr_addr_i (wr_addr_q),
      .wr_data_i (wr_data_q),
      .rd_addr_i (rd_mem_addr),
      .rd_data_o (rd_mem_data)
   );

   pdpram_rd_path #(
      .DATA_W   (DATA_W),
      .AW       (AW),
      .ADDR_REG (RD_ADDR_REG),
      .DATA_REG (RD_DATA_REG)
   ) u_rd (
      .clk_i      (rclk_e),
      .rst_i      (rst_e),
      .ce_i       (rce_e),
      .addr_i     (rd_addr_i),
      .mem_addr_o (rd_mem_addr),
      .mem_data_i (rd_mem_data),
      .data_o     (rd_data_o)
   );
endmodule

// File: rtl/pdpram_chk.sv
module pdpram_chk #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned AW          = 11,
   parameter bit          RD_ADDR_REG = 1'b1,
   parameter bit          RD_DATA_REG = 1'b1,
   parameter logic [1:0]  CS_MATCH    = 2'b11
) (
   input logic              wclk_e,
   input logic              rclk_e,
   input logic              wce_e,
   input logic              rce_e,
   input logic              rst_e,
   input logic              wr_en_i,
   input logic [1:0]        wr_sel_i,
   input logic [AW-1:0]     wr_addr_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic              wr_go_q,
   input logic [AW-1:0]     wr_addr_q,
   input logic [DATA_W-1:0] wr_data_q,
   input logic [AW-1:0]     rd_addr_i,
   input logic [AW-1:0]     rd_mem_addr,
   input logic [DATA_W-1:0] rd_data_o
);
   AST_WR_SEL_GATE: assert property (@(posedge wclk_e) disable iff (rst_e)
      (wce_e && !(wr_en_i && (wr_sel_i == CS_MATCH))) |=> !wr_go_q); // R2

   AST_WR_CAPTURE: assert property (@(posedge wclk_e) disable iff (rst_e)
      wce_e |=> (wr_addr_q == $past(wr_addr_i)) && (wr_data_q == $past(wr_data_i))); // R3

   AST_WR_HOLD: assert property (@(posedge wclk_e) disable iff (rst_e)
      !wce_e |=> $stable(wr_go_q) && $stable(wr_addr_q) && $stable(wr_data_q)); // R2

   generate
      if (RD_ADDR_REG) begin : g_a_addr
         AST_RD_ADDR_PIPE: assert property (@(posedge rclk_e) disable iff (rst_e)
            rce_e |=> rd_mem_addr == $past(rd_addr_i)); // R4
      end
      if (RD_DATA_REG) begin : g_a_data
         AST_RD_HOLD: assert property (@(posedge rclk_e) disable iff (rst_e)
            !rce_e |=> $stable(rd_data_o)); // R5
         AST_RST_ZERO: assert property (@(posedge rclk_e)
            rst_e |-> rd_data_o == '0); // R7
      end
   endgenerate
endmodule

bind pdpram_top pdpram_chk #(
   .DATA_W      (DATA_W),
   .AW          (AW),
   .RD_ADDR_REG (RD_ADDR_REG),
   .RD_DATA_REG (RD_DATA_REG),
   .CS_MATCH    (CS_MATCH)
) u_chk (
   .wclk_e      (wclk_e),
   .rclk_e      (rclk_e),
   .wce_e       (wce_e),
   .rce_e       (rce_e),
   .rst_e       (rst_e),
   .wr_en_i     (wr_en_i),
   .wr_sel_i    (wr_sel_i),
   .wr_addr_i   (wr_addr_i),
   .wr_data_i   (wr_data_i),
   .wr_go_q     (wr_go_q),
   .wr_addr_q   (wr_addr_q),
   .wr_data_q   (wr_data_q),
   .rd_addr_i   (rd_addr_i),
   .rd_mem_addr (rd_mem_addr),
   .rd_data_o   (rd_data_o)
);

// File: tb/pdpram_top_tb_top.sv
module pdpram_top_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_g, rst_l, wce, we, rce;
   logic [1:0]  wcs;
   logic [10:0] waddr, raddr;
   logic [31:0] wdata;
   logic [7:0]  rd8;
   logic [15:0] rd16;
   logic [31:0] rd32;
   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // 8-bit, both read registers, default polarities
   pdpram_top dut_i (
      .rst_glb_i(rst_g), .rst_loc_i(rst_l), .wr_clk_i(clk), .wr_ce_i(wce),
      .wr_en_i(we), .wr_sel_i(wcs), .wr_addr_i(waddr), .wr_data_i(wdata[7:0]),
      .rd_clk_i(clk), .rd_ce_i(rce), .rd_addr_i(raddr), .rd_data_o(rd8));

   // 16-bit, data register only, inverted enables and local reset (R8)
   pdpram_top #(.DATA_W(16), .RD_ADDR_REG(1'b0), .RD_DATA_REG(1'b1),
                .WCE_INV(1'b1), .RCE_INV(1'b1), .LRST_INV(1'b1)) dut_c (
      .rst_glb_i(rst_g), .rst_loc_i(~rst_l), .wr_clk_i(clk), .wr_ce_i(~wce),
      .wr_en_i(we), .wr_sel_i(wcs), .wr_addr_i(waddr[9:0]), .wr_data_i(wdata[15:0]),
      .rd_clk_i(clk), .rd_ce_i(~rce), .rd_addr_i(raddr[9:0]), .rd_data_o(rd16));

   // 32-bit, fully combinational read
   pdpram_top #(.DATA_W(32), .RD_ADDR_REG(1'b0), .RD_DATA_REG(1'b0)) dut_z (
      .rst_glb_i(rst_g), .rst_loc_i(rst_l), .wr_clk_i(clk), .wr_ce_i(wce),
      .wr_en_i(we), .wr_sel_i(wcs), .wr_addr_i(waddr[8:0]), .wr_data_i(wdata),
      .rd_clk_i(clk), .rd_ce_i(rce), .rd_addr_i(raddr[8:0]), .rd_data_o(rd32));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [10:0] a, input logic [31:0] d,
                     input logic [1:0] sel, input logic en, input logic ce);
      @(negedge clk);
      wce = ce; we = en; wcs = sel; waddr = a; wdata = d;
      @(negedge clk);
      wce = 1'b1; we = 1'b0;
      @(negedge clk);
   endtask

   // full read on all three variants, each sampled at its own latency
   task automatic rd(input logic [10:0] a, input logic [31:0] d, input string req);
      @(negedge clk);
      raddr = a; rce = 1'b1;
      #1 chk(req, "comb rd32", rd32, d);
      @(negedge clk);
      chk(req, "1-stage rd16", {16'd0, rd16}, {16'd0, d[15:0]});
      @(negedge clk);
      chk(req, "2-stage rd8", {24'd0, rd8}, {24'd0, d[7:0]});
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      chk("R7", "rd8 in reset", {24'd0, rd8}, 32'd0);
      chk("R7", "rd16 in reset", {16'd0, rd16}, 32'd0);
      rst_g = 1'b0;
   endtask

   task automatic t_basic;
      wr(11'd5, 32'hA1B2C3D4, 2'b11, 1'b1, 1'b1);
      wr(11'd6, 32'h11223344, 2'b11, 1'b1, 1'b1);
      rd(11'd5, 32'hA1B2C3D4, "R3");
      rd(11'd6, 32'h11223344, "R3");
   endtask

   task automatic t_top;
      wr(11'd2047, 32'hCAFEF00D, 2'b11, 1'b1, 1'b1);
      wr(11'd0,    32'h0BADBEEF, 2'b11, 1'b1, 1'b1);
      rd(11'd2047, 32'hCAFEF00D, "R1");
      rd(11'd0,    32'h0BADBEEF, "R1");
   endtask

   task automatic t_gate;
      wr(11'd5, 32'hFFFFFFFF, 2'b01, 1'b1, 1'b1);
      rd(11'd5, 32'hA1B2C3D4, "R2 sel=01");
      wr(11'd5, 32'hFFFFFFFF, 2'b10, 1'b1, 1'b1);
      rd(11'd5, 32'hA1B2C3D4, "R2 sel=10");
      wr(11'd5, 32'hFFFFFFFF, 2'b11, 1'b0, 1'b1);
      rd(11'd5, 32'hA1B2C3D4, "R2 we=0");
      wr(11'd5, 32'hFFFFFFFF, 2'b11, 1'b1, 1'b0);
      rd(11'd5, 32'hA1B2C3D4, "R2 R8 ce off");
   endtask

   task automatic t_latency;
      rd(11'd5, 32'hA1B2C3D4, "R4 prime");
      @(negedge clk);
      raddr = 11'd6;
      #1;
      chk("R4", "comb follows at once", rd32, 32'h11223344);
      chk("R4", "1-stage before edge", {16'd0, rd16}, 32'h0000C3D4);
      @(negedge clk);
      chk("R4", "1-stage after 1 edge", {16'd0, rd16}, 32'h00003344);
      chk("R4", "2-stage after 1 edge", {24'd0, rd8}, 32'h000000D4);
      @(negedge clk);
      chk("R4", "2-stage after 2 edges", {24'd0, rd8}, 32'h00000044);
   endtask

   task automatic t_hold;
      rd(11'd5, 32'hA1B2C3D4, "R5 prime");
      @(negedge clk);
      rce = 1'b0; raddr = 11'd6;
      repeat (3) @(negedge clk);
      chk("R5", "rd8 held", {24'd0, rd8}, 32'h000000D4);
      chk("R5 R8", "rd16 held", {16'd0, rd16}, 32'h0000C3D4);
      rce = 1'b1;
   endtask

   task automatic t_collide;
      @(negedge clk);
      wce = 1'b1; we = 1'b1; wcs = 2'b11; waddr = 11'd6; wdata = 32'h55667788;
      raddr = 11'd6; rce = 1'b1;
      @(negedge clk);
      we = 1'b0;
      @(negedge clk);
      chk("R6", "old word on commit edge", {24'd0, rd8}, 32'h00000044);
      @(negedge clk);
      chk("R6", "new word one edge later", {24'd0, rd8}, 32'h00000088);
   endtask

   task automatic t_rst_keep;
      @(negedge clk);
      rst_l = 1'b1;
      #1;
      chk("R7", "local reset clears rd8", {24'd0, rd8}, 32'd0);
      chk("R7 R8", "inverted local reset clears rd16", {16'd0, rd16}, 32'd0);
      @(negedge clk);
      rst_l = 1'b0;
      rd(11'd6, 32'h55667788, "R7 array kept");
      // a sampled write is cancelled by reset before it commits
      wr(11'd7, 32'h12345678, 2'b11, 1'b1, 1'b1);
      @(negedge clk);
      wce = 1'b1; we = 1'b1; wcs = 2'b11; waddr = 11'd7; wdata = 32'hDEADDEAD;
      @(negedge clk);
      we = 1'b0;
      #1 rst_g = 1'b1;
      @(negedge clk);
      rst_g = 1'b0;
      rd(11'd7, 32'h12345678, "R7 pending write dropped");
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_g = 1'b1; rst_l = 1'b0; wce = 1'b1; we = 1'b0; wcs = 2'b00;
      waddr = '0; wdata = '0; rce = 1'b1; raddr = '0;
      t_reset();
      t_basic();
      t_top();
      t_gate();
      t_latency();
      t_hold();
      t_collide();
      t_rst_keep();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule